// File: doc/BRIEF.md
# Time Slot Interchange Switch

This block moves 8-bit channels between serial time-division streams. Four receive streams and four transmit streams each carry 32 channels per frame, for 128 channels in each direction. Every received byte is assembled from its serial bits and stored in a data memory indexed by stream and channel. A host fills a connection memory that holds one two-byte entry per transmit channel. For each transmit slot the entry either names a received channel, whose latest stored byte is sent, or supplies a constant byte that is sent every frame. Several outputs may name the same source, which broadcasts that source.

One bit clock drives all streams. A frame pulse, high in the last bit cycle of a frame, realigns the internal bit and slot count. The byte for each transmit slot is read one slot early and loaded into a parallel-to-serial shifter at the end of the previous slot. Each transmit bit has its own output-enable. That enable comes from a per-channel control bit, a global force-processor input, and a master drive-enable input that turns off every output at once.

Top module: `tsi_switch`

## Requirements
- R1: Receive bits are taken MSB first, one per clock. The byte of stream s, slot k is stored at data memory address {s, k} on the clock edge that ends the slot.
- R2: In connection mode an output slot sends the data memory byte at the address in the low byte of its entry. Bits 6:5 give the stream and bits 4:0 the channel. Bit 7 is ignored. Any number of outputs may name one source.
- R3: In processor mode an output slot sends the low byte of its entry itself, in every frame, until the host rewrites it.
- R4: The byte for transmit slot k is loaded on the edge that ends slot k-1 (slot 31 of the previous frame for k = 0). It is sent MSB first during the eight bit cycles of slot k.
- R5: Through-delay: a source byte from slot j reaches output slot k in the same frame only if j is lower than the fetch slot (k-1 mod 32, with the fetch frame being the previous one for k = 0). Otherwise the byte from one frame earlier is sent. Same-slot switching therefore arrives one frame later, and the minimum delay is two slots.
- R6: High-byte bit 2 selects processor mode (1) or connection mode (0). High-byte bit 0 enables the channel (1) or disables its output (0). Both are captured with the byte and hold for the whole slot.
- R7: With proc_all high, every channel behaves as if high-byte bits 2 and 0 were both 1.
- R8: With ode low, every bit of tx_oe is 0 at once, whatever the other settings.
- R9: The bit and slot count runs freely over 256 cycles. A frame_sync pulse makes the next cycle bit 0 of slot 0.
- R10: Reset clears the connection memory, the count and the output state, so every tx_oe bit reads 0 until channels are enabled.
- R11: A host write with wr_high = 1 writes the high (control) byte, and with wr_high = 0 the low byte, of the entry at wr_addr = {stream, channel}. The write takes effect on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the last bit cycle of a frame |
| rx | input | 4 | Serial receive streams |
| wr_en | input | 1 | Connection memory write strobe |
| wr_high | input | 1 | 1 selects the control byte, 0 the low byte |
| wr_addr | input | 7 | Entry address {stream, channel} |
| wr_data | input | 8 | Write data |
| proc_all | input | 1 | Force every channel to enabled processor mode |
| ode | input | 1 | Master output drive enable |
| tx_dat | output | 4 | Serial transmit data |
| tx_oe | output | 4 | Per-stream output enable (0 = high impedance) |

## Verification
The assertions assume that frame_sync, when used to realign, is raised only in a last bit cycle or is followed by frames in which stale slot data is tolerated. They also assume that connection memory writes do not coincide with the fetch of the entry being written. The stimulus keeps to this by writing a full configuration during one unchecked frame and letting one more frame pass before any output is compared. After a deliberate mid-frame realignment, two unchecked frames pass. Receive bytes are random from a fixed seed. Directed configurations cover broadcast, the same-slot, previous-slot and two-slot delay cases, processor mode, the global override and the master enable.

// File: rtl/tsi_switch.sv
module tsi_switch #(
  parameter int N_STRM = 4,
  parameter int N_CHAN = 32,
  parameter int W      = 8
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   frame_sync,
  input  logic [N_STRM-1:0]                      rx,
  input  logic                                   wr_en,
  input  logic                                   wr_high,
  input  logic [$clog2(N_STRM*N_CHAN)-1:0]       wr_addr,
  input  logic [W-1:0]                           wr_data,
  input  logic                                   proc_all,
  input  logic                                   ode,
  output logic [N_STRM-1:0]                      tx_dat,
  output logic [N_STRM-1:0]                      tx_oe
);
  localparam int SW = $clog2(N_STRM);
  localparam int CW = $clog2(N_CHAN);
  localparam int BW = $clog2(W);
  localparam int AW = SW + CW;
  localparam int PW = CW + BW;
  localparam int NE = N_STRM * N_CHAN;
  localparam int MODE_BIT = 2;
  localparam int EN_BIT   = 0;

  logic [PW-1:0] pos_q;
  logic [BW-1:0] bit_i;
  logic [CW-1:0] slot_i, nxt_slot;
  logic          last_bit;

  assign bit_i    = pos_q[BW-1:0];
  assign slot_i   = pos_q[PW-1:BW];
  assign nxt_slot = slot_i + 1'b1;
  assign last_bit = (bit_i == BW'(W-1));

  always_ff @(posedge clk) begin
    if (!rst_n)          pos_q <= '0;
    else if (frame_sync) pos_q <= '0;
    else                 pos_q <= pos_q + 1'b1;
  end

  logic [W-1:0] dm     [NE];
  logic [W-1:0] cm_hi  [NE];
  logic [W-1:0] cm_lo  [NE];
  logic [W-2:0] in_sh  [N_STRM];

  always_ff @(posedge clk) begin
    for (int s = 0; s < N_STRM; s++) begin
      in_sh[s] <= {in_sh[s][W-3:0], rx[s]};
      if (last_bit) dm[AW'({SW'(s), slot_i})] <= {in_sh[s], rx[s]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NE; i++) begin
        cm_hi[i] <= '0;
        cm_lo[i] <= '0;
      end
    end else if (wr_en) begin
      if (wr_high) cm_hi[wr_addr] <= wr_data;
      else         cm_lo[wr_addr] <= wr_data;
    end
  end

  logic [W-1:0] out_sh [N_STRM];
  logic [W-1:0] f_hi   [N_STRM];
  logic [W-1:0] f_lo   [N_STRM];
  logic [W-1:0] f_byte [N_STRM];
  logic [N_STRM-1:0] f_proc, f_en, oe_q;

  for (genvar t = 0; t < N_STRM; t++) begin : g_out
    assign f_hi[t]   = cm_hi[{SW'(t), nxt_slot}];
    assign f_lo[t]   = cm_lo[{SW'(t), nxt_slot}];
    assign f_proc[t] = proc_all | f_hi[t][MODE_BIT];
    assign f_en[t]   = proc_all | f_hi[t][EN_BIT];
    assign f_byte[t] = f_proc[t] ? f_lo[t] : dm[f_lo[t][AW-1:0]];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_sh[t] <= '0;
        oe_q[t]   <= 1'b0;
      end else if (last_bit) begin
        out_sh[t] <= f_byte[t];
        oe_q[t]   <= f_en[t];
      end else begin
        out_sh[t] <= out_sh[t] << 1;
      end
    end

    assign tx_dat[t] = out_sh[t][W-1];
    assign tx_oe[t]  = oe_q[t] & ode;

    AST_PROC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && f_proc[t]) |=> (out_sh[t] == $past(f_lo[t]))); // R3
    AST_FORCE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (last_bit && proc_all) |=> (tx_oe[t] || !ode)); // R7
    AST_ENABLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!last_bit && ode) |=> (!ode || $stable(tx_oe[t]))); // R6
  end

  AST_MASTER_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ode |-> (tx_oe == '0)); // R8
  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (pos_q == '0)); // R9
  AST_SLOT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_sync && last_bit) |=> (bit_i == '0 && slot_i == $past(nxt_slot))); // R4
endmodule

// File: tb/test_tsi_switch.sv
module test_tsi_switch;
  logic clk = 0, rst_n = 0, frame_sync = 0, wr_en = 0, wr_high = 0, proc_all = 0, ode = 1;
  logic [3:0] rx = 0;
  logic [6:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic [3:0] tx_dat, tx_oe;

  tsi_switch i_tsi_switch (.*);

  always #10 clk = ~clk;

  int nchk = 0, nerr = 0, fr = 0, sync_at = -1;
  logic [7:0] p = 0;
  logic [7:0] hi_m [128];
  logic [7:0] lo_m [128];
  logic [7:0] rxh [64][128];
  logic [7:0] cur [4];
  logic [7:0] acc [4];

  task automatic check(input string rq, input int got, input int exp, input string what);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s frame %0d pos %0d: got %0h expected %0h", rq, what, fr, p, got, exp);
    end
  endtask

  // R5 model: fetch at end of slot k-1; sources from later or equal slots come from one frame earlier
  function automatic logic [7:0] exp_byte(input int k, input logic [6:0] a);
    logic [6:0] src;
    int j, r, frr, use_f;
    src = lo_m[a][6:0];
    j = int'(src[4:0]);
    r = (k + 31) % 32;
    frr = (k == 0) ? fr - 1 : fr;
    use_f = (j < r) ? frr : frr - 1;
    return rxh[use_f & 63][src];
  endfunction

  task automatic cyc(input bit do_chk, input bit do_wr);
    logic [4:0] k;
    logic [2:0] b;
    @(negedge clk);
    k = p[7:3];
    b = p[2:0];
    for (int t = 0; t < 4; t++) begin
      logic [6:0] a;
      logic en, pr;
      a = {t[1:0], k};
      en = ode && (proc_all || hi_m[a][0]);
      pr = proc_all || hi_m[a][2];
      acc[t] = {acc[t][6:0], tx_dat[t]};
      if (do_chk && b == 0)
        check(!ode ? "R8" : (proc_all ? "R7" : "R6"), int'(tx_oe[t]), int'(en), "enable");
      // R4: byte collected MSB first over the slot
      if (do_chk && b == 7 && en)
        check(pr ? (proc_all ? "R7" : "R3") : "R2 R5 R1", int'(acc[t]),
              int'(pr ? lo_m[a] : exp_byte(int'(k), a)), "byte");
    end
    for (int s = 0; s < 4; s++) begin
      if (b == 0) begin
        cur[s] = 8'($urandom);
        rxh[fr & 63][{s[1:0], k}] = cur[s];
      end
      rx[s] = cur[s][7 - b];
    end
    wr_en = do_wr;
    wr_high = !p[7];
    wr_addr = p[6:0];
    wr_data = p[7] ? lo_m[p[6:0]] : hi_m[p[6:0]];
    frame_sync = (p == 8'd255) || (int'(p) == sync_at);
    if (frame_sync) p = 0; else p = p + 1;
    if (p == 0) fr++;
  endtask

  task automatic frame(input bit do_chk, input bit do_wr);
    for (int c = 0; c < 256; c++) cyc(do_chk, do_wr);
  endtask

  // R11: full configuration written through the host port, one settle frame, then checks
  task automatic scenario(input int n_chk);
    frame(0, 1);
    frame(0, 0);
    for (int f = 0; f < n_chk; f++) frame(1, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 128; i++) begin hi_m[i] = 0; lo_m[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10: after reset all channels are disabled
    frame(1, 0);

    // R2: broadcast stream 1 channel 5 to every output
    for (int i = 0; i < 128; i++) begin hi_m[i] = 8'h01; lo_m[i] = 8'h25; end
    scenario(2);

    // R5: same slot, previous slot, two slots back, next slot; bit 7 set on stream 3 (R2)
    for (int i = 0; i < 128; i++) begin
      int t, k, d;
      t = i / 32; k = i % 32;
      d = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 2 : 31;
      hi_m[i] = 8'h01;
      lo_m[i] = {(t == 3), t[1:0], 5'((k - d + 32) % 32)};
    end
    scenario(2);

    // R3: processor mode constant bytes repeat every frame
    for (int i = 0; i < 128; i++) begin hi_m[i] = 8'h05; lo_m[i] = 8'($urandom); end
    scenario(3);

    // R6: random mixes of mode, enable and unused control bits
    for (int n = 0; n < 3; n++) begin
      for (int i = 0; i < 128; i++) begin hi_m[i] = 8'($urandom); lo_m[i] = 8'($urandom); end
      scenario(2);
    end

    // R7: global processor override
    proc_all = 1;
    scenario(2);
    proc_all = 0;

    // R8: master enable low for whole frames, and an immediate drop mid-frame
    ode = 0;
    frame(1, 0);
    ode = 1;
    for (int i = 0; i < 128; i++) hi_m[i] = 8'h01;
    scenario(1);
    repeat (40) cyc(1, 0);
    ode = 0;
    #1;
    check("R8", int'(tx_oe), 0, "immediate off");
    ode = 1;

    // R9: realign mid-frame, then data must follow the new frame position
    for (int i = 0; i < 128; i++) begin hi_m[i] = 8'($urandom); lo_m[i] = 8'($urandom); end
    frame(0, 1);
    sync_at = int'(p) + 20;
    repeat (30) cyc(0, 0);
    sync_at = -1;
    frame(0, 0);
    frame(0, 0);
    frame(1, 0);
    frame(1, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    nerr++;
    nchk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule